// File: doc/BRIEF.md
# Three-Sector Bridge Pole Modulator

This block drives the gates of a three-leg, two-level bridge that switches only a few times per fundamental period. Each cycle it takes a 16-bit phase angle from an external phase accumulator, locked to the grid, and a modulation index word. It splits the turn into three 120-degree sectors. Inside each sector it steps through three neighbouring active pole states. The time spent on them is an angle proportional to the index. For the rest of the sector it holds a zero state. Because the sector edges follow the incoming angle, the fundamental of the bridge output stays in phase with that angle.

Each leg carries one complementary switch pair, so each pole sits at either the positive or the negative bus rail. A per-leg dead-time stage turns both switches of a leg off for a programmable number of clock cycles at every change of that leg's pole. While the synchronous enable is low, every gate is held off. After reset, or when enable returns, the block waits for the angle to wrap before it drives anything, so the pattern always starts cleanly in the first sector.

Top module: `sector_bridge_mod`

## Requirements
- R1: Pole bit k of the 3-bit pole state (bit 0 leg a, bit 1 leg b, bit 2 leg c) set to 1 turns on the upper gate of leg k and a 0 turns on the lower gate. The angle is 16 bits with 65536 counts per turn. Sector I covers angles 0..21845, sector II covers 21846..43690 and sector III covers 43691..65535.
- R2: Let step = floor(min(index, 32768) * 7282 / 32768) and let pos = angle minus the sector start. The pole state is the lead vector for pos < step, the middle vector for pos < 2*step, and the trail vector for pos < 3*step. As {c,b,a} these are: sector I 101, 001, 011; sector II 011, 010, 110; sector III 110, 100, 101.
- R3: For pos >= 3*step the pole state is the zero state 111, with all upper gates on. This state differs from the trail vector before it and from the lead vector after it in one leg only.
- R4: An index above 32768 (Q1.15 one) acts as 32768. At that value the zero state never occurs, at any angle.
- R5: An index of 0 gives the zero state 111 at every angle.
- R6: The upper and lower gates of one leg are never on at the same time. With a nonzero dead time, a leg never goes straight from one gate to the other.
- R7: When a leg's pole changes, both gates of that leg are off for exactly dead_cyc_i clock cycles, and then the new gate turns on. With dead_cyc_i = 0 the gates swap directly. An angle change reaches the dead-time stage two clock edges after it is applied.
- R8: A low en_i sampled at a clock edge turns every gate off from that edge on.
- R9: After reset, or after en_i rises, all gates stay off until a clock edge sees the angle MSB fall from 1 to 0 while en_i is high. Then the pattern for the present angle starts, after one dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Synchronous enable; low forces all gates off |
| theta_i | input | 16 | Fundamental phase angle, 65536 counts per turn |
| mod_idx_i | input | 16 | Modulation index, unsigned Q1.15, clamped to one |
| dead_cyc_i | input | 8 | Dead time in clock cycles |
| gate_hi_o | output | 3 | Upper gate per leg (bit 0 leg a) |
| gate_lo_o | output | 3 | Lower gate per leg (bit 0 leg a) |

## Verification
Several rules are checked by assertions on every cycle. These are the off-state after enable drops, the single start point at an angle wrap, the fixed pole states at full and zero index, the off window after each leg change, and the absence of a direct gate swap when dead time is nonzero. Other behaviour only the bench scenarios can show. That covers the exact pole state at chosen positions in each sector, the clamp of out-of-range indices, the exact length of the dead-time gap with and without delay, and the silence of the gates between re-enable and the next wrap.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    localparam int NUM_LEGS = 3;

    typedef enum logic [1:0] {
        SEC_I   = 2'd0,
        SEC_II  = 2'd1,
        SEC_III = 2'd2
    } sector_e;

    typedef enum logic [1:0] {
        SLOT_LEAD  = 2'd0,
        SLOT_MID   = 2'd1,
        SLOT_TRAIL = 2'd2,
        SLOT_ZERO  = 2'd3
    } slot_e;

    typedef struct packed {
        sector_e sec;
        slot_e   slot;
    } dwell_t;

    typedef logic [NUM_LEGS-1:0] pole_t;

    // Pole state for a sector and dwell slot. The sector's held leg stays
    // high across all active slots; the trailing neighbour joins at the lead
    // slot and the leading neighbour joins at the trail slot.
    function automatic pole_t pole_of(dwell_t d);
        pole_t held;
        pole_t ahead;
        pole_t behind;
        pole_t res;
        case (d.sec)
            SEC_II:  held = 3'b010;
            SEC_III: held = 3'b100;
            default: held = 3'b001;
        endcase
        ahead  = {held[1:0], held[2]};
        behind = {held[0], held[2:1]};
        case (d.slot)
            SLOT_LEAD:  res = held | behind;
            SLOT_MID:   res = held;
            SLOT_TRAIL: res = held | ahead;
            default:    res = '1;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/sbm_dwell_decode.sv
module sbm_dwell_decode
    import sbm_pkg::*;
#(
    parameter int ANG_W = 16,
    parameter int MF_W  = 16
) (
    input  logic [ANG_W-1:0] theta_i,
    input  logic [MF_W-1:0]  mf_i,
    output dwell_t           dwell_o
);

    localparam longint FULL_ANG = 64'd1 << ANG_W;
    localparam logic [ANG_W-1:0] SEC2_START = ANG_W'((FULL_ANG + 2) / 3);
    localparam logic [ANG_W-1:0] SEC3_START = ANG_W'((2 * FULL_ANG + 2) / 3);
    // one ninth of a turn: one active slot at unity index
    localparam logic [ANG_W-1:0] STEP_K     = ANG_W'((FULL_ANG + 8) / 9);
    localparam logic [MF_W-1:0]  MF_ONE     = {1'b1, {(MF_W-1){1'b0}}};
    localparam int PW = MF_W + ANG_W;
    localparam int EW = ANG_W + 2;

    logic [MF_W-1:0]  mf_c;
    logic [PW-1:0]    prod;
    logic [ANG_W-1:0] step;
    logic [EW-1:0]    b1, b2, b3;
    logic [ANG_W-1:0] base;
    logic [EW-1:0]    pos;

    always_comb begin
        mf_c = (mf_i > MF_ONE) ? MF_ONE : mf_i;
        prod = PW'(mf_c) * PW'(STEP_K);
        step = ANG_W'(prod >> (MF_W - 1));
        b1   = EW'(step);
        b2   = b1 << 1;
        b3   = b1 + b2;

        if (theta_i < SEC2_START) begin
            dwell_o.sec = SEC_I;
            base        = '0;
        end else if (theta_i < SEC3_START) begin
            dwell_o.sec = SEC_II;
            base        = SEC2_START;
        end else begin
            dwell_o.sec = SEC_III;
            base        = SEC3_START;
        end
        pos = EW'(theta_i - base);

        if (pos < b1)      dwell_o.slot = SLOT_LEAD;
        else if (pos < b2) dwell_o.slot = SLOT_MID;
        else if (pos < b3) dwell_o.slot = SLOT_TRAIL;
        else               dwell_o.slot = SLOT_ZERO;
    end

endmodule

// File: rtl/sbm_leg_gate.sv
module sbm_leg_gate #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            live_i,
    input  logic            cmd_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);

    logic            applied_q;
    logic [DT_W-1:0] wait_q;
    logic            settled;

    always_ff @(posedge clk) begin
        if (rst) begin
            applied_q <= 1'b0;
            wait_q    <= '0;
        end else if (!live_i) begin
            applied_q <= cmd_i;
            wait_q    <= dead_i;
        end else if (cmd_i != applied_q) begin
            applied_q <= cmd_i;
            wait_q    <= dead_i;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign settled = live_i && (wait_q == '0);
    assign hi_o    = settled && applied_q;
    assign lo_o    = settled && !applied_q;

    // R7: a pole change with nonzero dead time opens an off window
    p_gap_after_change_r7: assert property (@(posedge clk) disable iff (rst)
        (live_i && (cmd_i != applied_q) && (dead_i != '0)) |=> (!hi_o && !lo_o));

    // R6: no direct swap from upper to lower while dead time is nonzero
    p_no_swap_down_r6: assert property (@(posedge clk) disable iff (rst)
        (hi_o && (dead_i != '0)) |=> !lo_o);

    // R6: no direct swap from lower to upper while dead time is nonzero
    p_no_swap_up_r6: assert property (@(posedge clk) disable iff (rst)
        (lo_o && (dead_i != '0)) |=> !hi_o);

endmodule

// File: rtl/sector_bridge_mod.sv
module sector_bridge_mod
    import sbm_pkg::*;
#(
    parameter int ANG_W = 16,
    parameter int MF_W  = 16,
    parameter int DT_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [ANG_W-1:0]    theta_i,
    input  logic [MF_W-1:0]     mod_idx_i,
    input  logic [DT_W-1:0]     dead_cyc_i,
    output logic [NUM_LEGS-1:0] gate_hi_o,
    output logic [NUM_LEGS-1:0] gate_lo_o
);

    localparam logic [MF_W-1:0] MF_ONE = {1'b1, {(MF_W-1){1'b0}}};

    dwell_t dwell;
    pole_t  pole_q;
    logic   msb_prev_q;
    logic   live_q;
    logic   wrap;

    sbm_dwell_decode #(
        .ANG_W (ANG_W),
        .MF_W  (MF_W)
    ) u_decode (
        .theta_i (theta_i),
        .mf_i    (mod_idx_i),
        .dwell_o (dwell)
    );

    assign wrap = msb_prev_q && !theta_i[ANG_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pole_q     <= '1;
            msb_prev_q <= 1'b0;
            live_q     <= 1'b0;
        end else begin
            pole_q     <= pole_of(dwell);
            msb_prev_q <= theta_i[ANG_W-1];
            if (!en_i)     live_q <= 1'b0;
            else if (wrap) live_q <= 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_LEGS; k++) begin : g_leg
        sbm_leg_gate #(
            .DT_W (DT_W)
        ) u_leg (
            .clk    (clk),
            .rst    (rst),
            .live_i (live_q),
            .cmd_i  (pole_q[k]),
            .dead_i (dead_cyc_i),
            .hi_o   (gate_hi_o[k]),
            .lo_o   (gate_lo_o[k])
        );
    end

    // R8: enable low turns every gate off after the sampling edge
    p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ((gate_hi_o == '0) && (gate_lo_o == '0)));

    // R9: running starts only after the angle MSB has fallen
    p_start_on_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(live_q) |-> (!$past(theta_i[ANG_W-1]) && $past(theta_i[ANG_W-1], 2)));

    // R4: full or clamped index never selects the zero state
    p_full_index_no_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (mod_idx_i >= MF_ONE) |=> (pole_q != 3'b111));

    // R5: zero index always selects the all-upper zero state
    p_zero_index_all_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (mod_idx_i == '0) |=> (pole_q == 3'b111));

endmodule

// File: tb/sector_bridge_mod_bench.sv
module sector_bridge_mod_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [15:0] theta = '0;
    logic [15:0] mf = '0;
    logic [7:0]  dead = '0;
    logic [2:0]  hi;
    logic [2:0]  lo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } item_t;

    item_t sbq[$];

    always #10 clk = ~clk;

    sector_bridge_mod u_sector_bridge_mod (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .theta_i    (theta),
        .mod_idx_i  (mf),
        .dead_cyc_i (dead),
        .gate_hi_o  (hi),
        .gate_lo_o  (lo)
    );

    // expected pole state {c,b,a} from the requirement tables (R1-R5 rules)
    function automatic logic [2:0] exp_vec(int th, int m);
        logic [2:0] lead [3];
        logic [2:0] mid  [3];
        logic [2:0] trail[3];
        int mc, step, sec, p;
        lead  = '{3'b101, 3'b011, 3'b110};
        mid   = '{3'b001, 3'b010, 3'b100};
        trail = '{3'b011, 3'b110, 3'b101};
        mc   = (m > 32768) ? 32768 : m;
        step = (mc * 7282) / 32768;
        if (th < 21846) begin sec = 0; p = th; end
        else if (th < 43691) begin sec = 1; p = th - 21846; end
        else begin sec = 2; p = th - 43691; end
        if (p < step)          return lead[sec];
        else if (p < 2 * step) return mid[sec];
        else if (p < 3 * step) return trail[sec];
        return 3'b111;
    endfunction

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // monitor: pops expected items and compares against the gates
    always @(negedge clk) begin
        item_t it;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (hi !== it.hi || lo !== it.lo) begin
                fails++;
                $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                         it.tag, hi, lo, it.hi, it.lo);
            end
        end
    end

    task automatic settle_push(input logic [2:0] eh, input logic [2:0] el, input string tag);
        repeat (int'(dead) + 5) @(posedge clk);
        #1;
        sbq.push_back('{eh, el, tag});
        wait (sbq.size() == 0);
    endtask

    task automatic step_to(input int th, input int m, input string tag);
        logic [2:0] e;
        @(negedge clk);
        theta = 16'(th);
        mf    = 16'(m);
        e = exp_vec(th, m);
        settle_push(e, ~e, tag);
    endtask

    task automatic wrap_into(input int th);
        @(negedge clk);
        theta = 16'hC000;
        repeat (3) @(negedge clk);
        theta = 16'(th);
    endtask

    task automatic gap_check(input int th, input int leg, input int expgap, input string tag);
        int gap = 0;
        bit overlap = 1'b0;
        @(negedge clk);
        theta = 16'(th);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (!hi[leg] && !lo[leg]) gap++;
            if ((hi & lo) != 3'b000) overlap = 1'b1;
        end
        chk(gap == expgap, $sformatf("%s: off cycles=%0d expected=%0d", tag, gap, expgap));
        chk(!overlap, $sformatf("R6 overlap during change: actual=1 expected=0"));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog R9 run hung: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        en   = 1'b1;
        mf   = 16'd16384;
        dead = 8'd3;
        theta = '0;
        repeat (3) @(negedge clk);
        chk(hi == 3'b000 && lo == 3'b000,
            $sformatf("R9 gates during reset: hi=%b lo=%b expected 000/000", hi, lo));
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(hi == 3'b000 && lo == 3'b000,
            $sformatf("R9 gates before first wrap: hi=%b lo=%b expected 000/000", hi, lo));

        // R9: first wrap starts the pattern
        wrap_into(1000);
        settle_push(3'b101, 3'b010, "R9 start after wrap");

        // R1 R2 R3: half index through all three sectors
        step_to(1000,  16384, "R1 R2 sector I lead");
        step_to(5000,  16384, "R1 R2 sector I mid");
        step_to(9000,  16384, "R1 R2 sector I trail");
        step_to(15000, 16384, "R3 sector I zero");
        step_to(22846, 16384, "R1 R2 sector II lead");
        step_to(26846, 16384, "R1 R2 sector II mid");
        step_to(30846, 16384, "R1 R2 sector II trail");
        step_to(40000, 16384, "R3 sector II zero");
        step_to(44691, 16384, "R1 R2 sector III lead");
        step_to(48691, 16384, "R1 R2 sector III mid");
        step_to(52691, 16384, "R1 R2 sector III trail");
        step_to(60000, 16384, "R3 sector III zero");

        // R4: unity and clamped index leave no zero state
        step_to(20000, 32768, "R4 unity index late sector I");
        step_to(21845, 65535, "R4 clamped index sector I end");
        step_to(15000, 65535, "R4 clamped index sector I");
        step_to(65535, 40000, "R4 clamped index sector III end");

        // R5: zero index
        step_to(5000,  0, "R5 zero index sector I");
        step_to(50000, 0, "R5 zero index sector III");

        // R7: dead time window on a single leg change
        step_to(1000, 16384, "R7 setup lead vector");
        gap_check(5000, 2, 3, "R7 leg c gap with dead=3");
        @(negedge clk);
        dead = 8'd0;
        repeat (4) @(negedge clk);
        gap_check(9000, 1, 0, "R7 leg b gap with dead=0");
        step_to(9000, 16384, "R7 trail after direct swap");

        // R8: disable turns gates off after one edge
        dead = 8'd2;
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(hi == 3'b000 && lo == 3'b000,
            $sformatf("R8 after disable: hi=%b lo=%b expected 000/000", hi, lo));

        // R9: re-enable waits for a wrap
        @(negedge clk);
        en = 1'b1;
        repeat (20) @(negedge clk);
        chk(hi == 3'b000 && lo == 3'b000,
            $sformatf("R9 re-enabled without wrap: hi=%b lo=%b expected 000/000", hi, lo));
        wrap_into(1000);
        settle_push(3'b101, 3'b010, "R9 restart after wrap");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule